// File: doc/BRIEF.md
# Two-Level Interrupt Enable Gate

This block holds the interrupt enable register of a small 8-bit microcontroller and uses it to qualify the pending requests of five sources: two external pins, two timer overflows and a serial port. The register has one master bit and one bit per source. A source's request goes through only when both the master bit and its own bit are set. Software reaches the register through two ports. The byte port reads and writes the whole register. The bit port addresses one bit at a time.

The pending flags come from outside as level inputs. Nothing in this block clears them. A masked flag still exists, and it produces a request again as soon as its enable is set. When more than one qualified request is pending, a fixed order picks one. The block then presents a registered request, the index of the chosen source and that source's vector address. A build parameter adds a sixth source, a third timer's overflow on bit 5, for the extended part.

Top module: `irq_enable_gate`

## Requirements
- R1: When synchronous reset is applied, the enable register becomes 00H and the outputs irq_req, irq_id, irq_vec, byte_rdata and bit_rdata all become 0.
- R2: A byte write with address A8H loads the register. A byte write to any other address changes nothing. byte_rdata shows, one cycle later, the register contents held before that edge when byte_addr is A8H, and 00H for any other address.
- R3: A bit write at address A8H+n, for n from 0 to 7, changes only bit n. A bit write outside A8H–AFH changes nothing. bit_rdata shows, one cycle later, the addressed bit as held before that edge, and 0 outside that range.
- R4: When a byte write and a bit write both hit the register in the same cycle, the byte value is applied first and the bit write is applied on top of it.
- R5: Bit 6 always reads 0, and writes to it are ignored. Bit 5 behaves the same way unless the third-timer option is built in.
- R6: While the master bit (bit 7) is 0, irq_req stays 0 whatever the flags and the per-source bits hold.
- R7: While the master bit is 1, a source is forwarded only if its own enable bit is also 1. Its bits are: external 0 on bit 0, timer 0 on bit 1, external 1 on bit 2, timer 1 on bit 3, serial on bit 4. A flag that stays high while masked is forwarded once its bit is set.
- R8: irq_vec is 0003H for external 0, 000BH for timer 0, 0013H for external 1, 001BH for timer 1 and 0023H for serial, which is 0003H + 8 × irq_id. When irq_req is 0, both irq_vec and irq_id read 0.
- R9: Among qualified requests, the lowest source index wins.
- R10: irq_req, irq_id and irq_vec are registered. Each reflects the register and the pend_flags as they stood before the previous clock edge.
- R11: A byte write of 81H and two single-bit writes of 1 to AFH and A8H leave the same register value, 81H.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_wr | input | 1 | Byte write strobe |
| byte_addr | input | 8 | Byte port address |
| byte_wdata | input | 8 | Byte write data |
| byte_rdata | output | 8 | Registered byte read data |
| bit_wr | input | 1 | Bit write strobe |
| bit_addr | input | 8 | Bit port address |
| bit_wdata | input | 1 | Bit write value |
| bit_rdata | output | 1 | Registered bit read data |
| pend_flags | input | 5 | Latched pending flags, bit i for source i |
| irq_req | output | 1 | Qualified request |
| irq_id | output | 3 | Index of the selected source |
| irq_vec | output | 16 | Vector address of the selected source |

## Verification
The bench builds the block with its default parameters: five sources, the register at A8H, vectors starting at 0003H and spaced 8 apart. With these values, all five vectors can be reached, as can both unimplemented bits (5 and 6) and bit addresses on both sides of the A8H–AFH window. Directed sequences and a pseudo-random run drive both write ports together, including in the same cycle. Every cycle, a behavioural reference model compares all five outputs.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;
  localparam int REG_BITS = 8;
  localparam int GLB_BIT  = 7;
  localparam int ID_W     = 3;

  typedef logic [REG_BITS-1:0] ien_t;

  // Bits that hold state: the master bit plus one bit per source.
  function automatic ien_t impl_mask(input int nsrc);
    ien_t m;
    m = '0;
    m[GLB_BIT] = 1'b1;
    for (int i = 0; i < nsrc; i++) m[i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/ien_reg.sv
module ien_reg
  import irq_gate_pkg::*;
#(
  parameter int   ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'hA8,
  parameter ien_t IMPL_MASK = 8'h9F
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_wr,
  input  logic [ADDR_W-1:0] byte_addr,
  input  logic [7:0]        byte_wdata,
  input  logic              bit_wr,
  input  logic [ADDR_W-1:0] bit_addr,
  input  logic              bit_wdata,
  output ien_t              ien_q,
  output logic [7:0]        byte_rdata,
  output logic              bit_rdata
);
  logic       byte_hit;
  logic       bit_hit;
  logic [2:0] bit_idx;
  ien_t       ien_nxt;

  assign byte_hit = (byte_addr == REG_ADDR);
  assign bit_hit  = (bit_addr[ADDR_W-1:3] == REG_ADDR[ADDR_W-1:3]);
  assign bit_idx  = bit_addr[2:0];

  // Byte write first, then the bit write lands on top of it.
  always_comb begin
    ien_nxt = ien_q;
    if (byte_wr && byte_hit) ien_nxt = byte_wdata;
    if (bit_wr && bit_hit)   ien_nxt[bit_idx] = bit_wdata;
  end

  for (genvar b = 0; b < REG_BITS; b++) begin : g_bit
    if (IMPL_MASK[b]) begin : g_ff
      always_ff @(posedge clk) begin
        if (rst) ien_q[b] <= 1'b0;
        else     ien_q[b] <= ien_nxt[b];
      end
    end else begin : g_tie
      assign ien_q[b] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      byte_rdata <= '0;
      bit_rdata  <= 1'b0;
    end else begin
      byte_rdata <= byte_hit ? ien_q : 8'h00;
      bit_rdata  <= bit_hit ? ien_q[bit_idx] : 1'b0;
    end
  end

  AST_RST_CLEARS: assert property (@(posedge clk) $past(rst) |-> (ien_q == '0) && (byte_rdata == '0)); // R1

  AST_BYTE_LOAD: assert property (@(posedge clk) disable iff (rst)
    (byte_wr && byte_hit && !(bit_wr && bit_hit)) |=> (ien_q == ($past(byte_wdata) & IMPL_MASK))); // R2

  AST_BIT_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (bit_wr && !(byte_wr && byte_hit)) |=> ($countones(ien_q ^ $past(ien_q)) <= 1)); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!(byte_wr && byte_hit) && !(bit_wr && bit_hit)) |=> $stable(ien_q)); // R2

  AST_RSVD_LOW: assert property (@(posedge clk) disable iff (rst)
    ((ien_q & ~IMPL_MASK) == '0)); // R5
endmodule

// File: rtl/irq_mask.sv
module irq_mask #(
  parameter int NUM_SRC = 5
) (
  input  logic [NUM_SRC-1:0] pend,
  input  logic [NUM_SRC-1:0] src_en,
  input  logic               glb_en,
  output logic [NUM_SRC-1:0] qual
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign qual[i] = glb_en & src_en[i] & pend[i];
  end
endmodule

// File: rtl/irq_select.sv
module irq_select
  import irq_gate_pkg::*;
#(
  parameter int NUM_SRC = 5,
  parameter int VEC_W   = 16,
  parameter logic [VEC_W-1:0] VEC_BASE = 16'h0003,
  parameter logic [VEC_W-1:0] VEC_STEP = 16'h0008
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] qual,
  output logic               irq_req,
  output logic [ID_W-1:0]    irq_id,
  output logic [VEC_W-1:0]   irq_vec
);
  logic            any_d;
  logic [ID_W-1:0] id_d;
  logic [VEC_W-1:0] vec_d;

  // Fixed order: lowest index wins.
  always_comb begin
    id_d = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (qual[i]) id_d = ID_W'(i);
    end
  end

  assign any_d = |qual;
  assign vec_d = VEC_BASE + (VEC_W'(id_d) * VEC_STEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req <= 1'b0;
      irq_id  <= '0;
      irq_vec <= '0;
    end else begin
      irq_req <= any_d;
      irq_id  <= any_d ? id_d : '0;
      irq_vec <= any_d ? vec_d : '0;
    end
  end

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !irq_req |-> (irq_vec == '0) && (irq_id == '0)); // R8

  AST_LOW_FIRST: assert property (@(posedge clk) disable iff (rst)
    qual[0] |=> irq_req && (irq_id == '0)); // R9

  AST_REQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (qual == '0) |=> !irq_req); // R10
endmodule

// File: rtl/irq_enable_gate.sv
module irq_enable_gate
  import irq_gate_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'hA8,
  parameter bit HAS_T2  = 1'b0,
  parameter int VEC_W   = 16,
  parameter logic [VEC_W-1:0] VEC_BASE = 16'h0003,
  parameter logic [VEC_W-1:0] VEC_STEP = 16'h0008,
  localparam int NUM_SRC = HAS_T2 ? 6 : 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               byte_wr,
  input  logic [ADDR_W-1:0]  byte_addr,
  input  logic [7:0]         byte_wdata,
  output logic [7:0]         byte_rdata,
  input  logic               bit_wr,
  input  logic [ADDR_W-1:0]  bit_addr,
  input  logic               bit_wdata,
  output logic               bit_rdata,
  input  logic [NUM_SRC-1:0] pend_flags,
  output logic               irq_req,
  output logic [ID_W-1:0]    irq_id,
  output logic [VEC_W-1:0]   irq_vec
);
  localparam ien_t IMPL_MASK = impl_mask(NUM_SRC);

  ien_t              ien_q;
  logic [NUM_SRC-1:0] qual;

  ien_reg #(
    .ADDR_W   (ADDR_W),
    .REG_ADDR (REG_ADDR),
    .IMPL_MASK(IMPL_MASK)
  ) u_reg (
    .clk       (clk),
    .rst       (rst),
    .byte_wr   (byte_wr),
    .byte_addr (byte_addr),
    .byte_wdata(byte_wdata),
    .bit_wr    (bit_wr),
    .bit_addr  (bit_addr),
    .bit_wdata (bit_wdata),
    .ien_q     (ien_q),
    .byte_rdata(byte_rdata),
    .bit_rdata (bit_rdata)
  );

  irq_mask #(.NUM_SRC(NUM_SRC)) u_mask (
    .pend  (pend_flags),
    .src_en(ien_q[NUM_SRC-1:0]),
    .glb_en(ien_q[GLB_BIT]),
    .qual  (qual)
  );

  irq_select #(
    .NUM_SRC (NUM_SRC),
    .VEC_W   (VEC_W),
    .VEC_BASE(VEC_BASE),
    .VEC_STEP(VEC_STEP)
  ) u_sel (
    .clk    (clk),
    .rst    (rst),
    .qual   (qual),
    .irq_req(irq_req),
    .irq_id (irq_id),
    .irq_vec(irq_vec)
  );

  AST_MASTER_OFF: assert property (@(posedge clk) disable iff (rst)
    !ien_q[GLB_BIT] |=> !irq_req); // R6

  AST_NO_PEND_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    ((pend_flags & ien_q[NUM_SRC-1:0]) == '0) |=> !irq_req); // R7

  AST_UNUSED_BITS: assert property (@(posedge clk) disable iff (rst)
    ((ien_q & ~IMPL_MASK) == '0)); // R5
endmodule

// File: tb/test_irq_enable_gate.sv
module test_irq_enable_gate;
  logic       clk = 1'b0;
  logic       rst;
  logic       byte_wr;
  logic [7:0] byte_addr;
  logic [7:0] byte_wdata;
  logic [7:0] byte_rdata;
  logic       bit_wr;
  logic [7:0] bit_addr;
  logic       bit_wdata;
  logic       bit_rdata;
  logic [4:0] pend_flags;
  logic       irq_req;
  logic [2:0] irq_id;
  logic [15:0] irq_vec;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // Reference model state.
  int m_ien = 0;
  int m_req = 0, m_id = 0, m_vec = 0, m_brd = 0, m_trd = 0;

  always #4 clk = ~clk; // 125 MHz

  irq_enable_gate i_irq_enable_gate (
    .clk(clk), .rst(rst),
    .byte_wr(byte_wr), .byte_addr(byte_addr), .byte_wdata(byte_wdata), .byte_rdata(byte_rdata),
    .bit_wr(bit_wr), .bit_addr(bit_addr), .bit_wdata(bit_wdata), .bit_rdata(bit_rdata),
    .pend_flags(pend_flags), .irq_req(irq_req), .irq_id(irq_id), .irq_vec(irq_vec)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // One clock: predict from the model, clock, compare, update the model.
  task automatic cyc(input string tag);
    int nxt, q, sel, ba, bi;
    ba = byte_addr;
    bi = bit_addr;
    if (rst) begin
      nxt = 0; m_req = 0; m_id = 0; m_vec = 0; m_brd = 0; m_trd = 0;
    end else begin
      q = (m_ien >> 7) & 1 ? (pend_flags & m_ien & 'h1F) : 0;
      sel = -1;
      for (int i = 4; i >= 0; i--) if ((q >> i) & 1) sel = i;
      m_req = (sel >= 0);
      m_id  = m_req ? sel : 0;
      m_vec = m_req ? 3 + 8 * sel : 0;
      m_brd = (ba == 'hA8) ? m_ien : 0;
      m_trd = (bi >= 'hA8 && bi <= 'hAF) ? (m_ien >> (bi - 'hA8)) & 1 : 0;
      nxt = m_ien;
      if (byte_wr && ba == 'hA8) nxt = byte_wdata;
      if (bit_wr && bi >= 'hA8 && bi <= 'hAF) begin
        if (bit_wdata) nxt = nxt | (1 << (bi - 'hA8));
        else           nxt = nxt & ~(1 << (bi - 'hA8));
      end
      nxt = nxt & 'h9F;
    end
    @(posedge clk);
    @(negedge clk);
    m_ien = nxt;
    chk(tag, "irq_req", irq_req, m_req);
    chk(tag, "irq_id", irq_id, m_id);
    chk(tag, "irq_vec", irq_vec, m_vec);
    chk(tag, "byte_rdata", byte_rdata, m_brd);
    chk(tag, "bit_rdata", bit_rdata, m_trd);
  endtask

  task automatic idle();
    byte_wr = 0; bit_wr = 0; byte_addr = 8'h00; bit_addr = 8'h00;
    byte_wdata = 8'h00; bit_wdata = 1'b0;
  endtask

  task automatic wbyte(input logic [7:0] a, input logic [7:0] d, input string tag);
    idle(); byte_wr = 1; byte_addr = a; byte_wdata = d; cyc(tag); idle();
  endtask

  task automatic wbit(input logic [7:0] a, input logic d, input string tag);
    idle(); bit_wr = 1; bit_addr = a; bit_wdata = d; cyc(tag); idle();
  endtask

  task automatic rd(input string tag);
    idle(); byte_addr = 8'hA8; cyc(tag); cyc(tag);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(8 * 20000);
    failures++;
    $display("FAIL watchdog timeout");
    summary();
  end

  initial begin
    logic [15:0] lfsr;
    idle();
    pend_flags = '0;
    rst = 1;
    cyc("R1"); cyc("R1"); cyc("R1");
    rst = 0;
    rd("R1");

    // R11 / R2: whole-byte 81H, flags all high -> external 0 wins
    pend_flags = 5'h1F;
    wbyte(8'hA8, 8'h81, "R11");
    cyc("R10"); rd("R2");
    // wrong byte address ignored
    wbyte(8'hA9, 8'hFF, "R2"); rd("R2");
    // bit-by-bit build of the same value
    wbyte(8'hA8, 8'h00, "R11");
    wbit(8'hAF, 1'b1, "R11"); wbit(8'hA8, 1'b1, "R11");
    rd("R11");
    // R5: unimplemented bits
    wbyte(8'hA8, 8'hFF, "R5"); rd("R5");
    wbit(8'hAE, 1'b1, "R5"); wbit(8'hAD, 1'b1, "R5");
    idle(); bit_addr = 8'hAE; cyc("R5"); cyc("R5");
    // R6: master off
    wbit(8'hAF, 1'b0, "R6"); cyc("R6"); cyc("R6");
    // R7 / R8: each source alone
    for (int i = 0; i < 5; i++) begin
      wbyte(8'hA8, 8'h80 | (8'h01 << i), "R8");
      cyc("R7"); cyc("R8");
    end
    // R9: priority among several
    wbyte(8'hA8, 8'h9F, "R9");
    pend_flags = 5'b11000; cyc("R9"); cyc("R9");
    pend_flags = 5'b10100; cyc("R9"); cyc("R9");
    pend_flags = 5'b10010; cyc("R9"); cyc("R9");
    // R7: flag held while masked, then unmasked
    pend_flags = 5'b00100;
    wbyte(8'hA8, 8'h80, "R7"); cyc("R7"); cyc("R7");
    wbit(8'hAA, 1'b1, "R7"); cyc("R7");
    // R4: same-cycle byte and bit writes
    idle(); byte_wr = 1; byte_addr = 8'hA8; byte_wdata = 8'h00;
    bit_wr = 1; bit_addr = 8'hAF; bit_wdata = 1'b1; cyc("R4");
    rd("R4");
    idle(); byte_wr = 1; byte_addr = 8'hA8; byte_wdata = 8'h9F;
    bit_wr = 1; bit_addr = 8'hA8; bit_wdata = 1'b0; cyc("R4");
    rd("R4");
    // R3: bit writes outside window and bit reads
    wbit(8'hB0, 1'b1, "R3"); wbit(8'hA7, 1'b0, "R3");
    rd("R3");
    for (int a = 8'hA6; a <= 8'hB1; a++) begin
      idle(); bit_addr = 8'(a); cyc("R3");
    end
    cyc("R3");
    // mixed pseudo-random traffic
    lfsr = 16'hACE1;
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      byte_wr    = lfsr[0];
      byte_addr  = lfsr[1] ? 8'hA8 : {4'hA, lfsr[5:2]};
      byte_wdata = lfsr[15:8];
      bit_wr     = lfsr[6];
      bit_addr   = {4'hA, lfsr[10:7]};
      bit_wdata  = lfsr[11];
      pend_flags = lfsr[13:9];
      cyc("R9");
    end
    idle();
    rst = 1; cyc("R1"); rst = 0; cyc("R1");
    summary();
  end
endmodule